// File: doc/BRIEF.md
# Byte-Addressed Data Memory Controller

This block is a word-organised data store addressed in bytes. An access carries a 32-bit byte address, a 32-bit write word, an enable and a 2-bit operation code. The code chooses between an aligned word read and three write widths: a single byte, an aligned halfword and an aligned word. Sub-word writes are steered into the proper byte lanes of the target word, and the other lanes of that word keep their contents.

Each operation has its own alignment rule. An access that breaks its rule raises an error flag in the same cycle and does not change storage. Storage depth is a parameter counted in words. Only the word-index bits just above the byte offset select the entry, so addresses beyond the depth wrap onto the same entries. Reads are combinational from the address, and writes commit on the rising clock edge.

Top module: `byte_mem_ctrl`

## Requirements
- R1: While rst_ni is low, every stored byte is cleared to zero, so an aligned word read after reset returns 0.
- R2: With en_i low, storage is never modified, err_o is 0 and rdata_o is 0, whatever op_i, addr_i and wdata_i carry.
- R3: op_i = 2'b00 with addr_i[1:0] = 0 drives rdata_o with the stored word in the same cycle, combinationally from addr_i.
- R4: op_i = 2'b01 writes wdata_i[7:0] into byte lane addr_i[1:0] of the target word on the rising edge. The layout is little-endian: lane k occupies bits 8k+7:8k. The other three lanes are unchanged.
- R5: op_i = 2'b10 with addr_i[0] = 0 writes wdata_i[15:0] into bits 15:0 of the word when addr_i[1] = 0, or into bits 31:16 when addr_i[1] = 1. The other halfword is unchanged.
- R6: op_i = 2'b11 with addr_i[1:0] = 0 replaces the whole target word with wdata_i on the rising edge.
- R7: A misaligned access raises err_o in the same cycle, forces rdata_o to 0 and leaves storage unchanged. An access is misaligned when op 00 or 11 has addr_i[1:0] != 0, or when op 10 has addr_i[0] = 1. A byte write is never misaligned.
- R8: The target word is selected by addr_i[IDX_W+1:2], where IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ only in those bits reach the same word.
- R9: During any write operation (op_i != 2'b00), rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears storage |
| en_i | input | 1 | Access enable |
| op_i | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, low-aligned for sub-word writes |
| rdata_o | output | 32 | Read word, 0 unless an aligned enabled read |
| err_o | output | 1 | Misaligned enabled access |

## Verification
Two results are checked, and each has its own due time. rdata_o and err_o are combinational, so they are due in the same cycle as the stimulus. A write becomes visible only to a read issued after the next rising edge. The driver applies each access just after a rising edge and queues the expected outputs, computed from a byte-lane model of the requirements. The monitor compares them at the following falling edge, before the write commits. A write's effect, or the absence of one, is then observed by a separate read that the driver issues in a later cycle.

// File: rtl/byte_mem_pkg.sv
package byte_mem_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_RD_WORD = 2'b00,
    OP_WR_BYTE = 2'b01,
    OP_WR_HALF = 2'b10,
    OP_WR_WORD = 2'b11
  } mem_op_e;
endpackage

// File: rtl/mem_align_chk.sv
module mem_align_chk
  import byte_mem_pkg::*;
(
  input  logic             en_i,
  input  logic [1:0]       op_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             misalign_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o
);
  logic bad;

  always_comb begin
    unique case (mem_op_e'(op_i))
      OP_RD_WORD: bad = (ofs_i != '0);
      OP_WR_BYTE: bad = 1'b0;
      OP_WR_HALF: bad = ofs_i[0];
      OP_WR_WORD: bad = (ofs_i != '0);
      default:    bad = 1'b1;
    endcase
  end

  assign misalign_o = en_i & bad;
  assign rd_ok_o    = en_i & ~bad & (op_i == OP_RD_WORD);
  assign wr_ok_o    = en_i & ~bad & (op_i != OP_RD_WORD);
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
  import byte_mem_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wword_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(l);
    always_comb begin
      unique case (mem_op_e'(op_i))
        OP_WR_BYTE: begin
          be_o[l]          = (ofs_i == LANE_ID);
          wword_o[8*l +: 8] = wdata_i[7:0];
        end
        OP_WR_HALF: begin
          be_o[l]          = (ofs_i[OFS_W-1] == LANE_ID[OFS_W-1]);
          wword_o[8*l +: 8] = LANE_ID[0] ? wdata_i[15:8] : wdata_i[7:0];
        end
        OP_WR_WORD: begin
          be_o[l]          = 1'b1;
          wword_o[8*l +: 8] = wdata_i[8*l +: 8];
        end
        default: begin
          be_o[l]          = 1'b0;
          wword_o[8*l +: 8] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mem_word_store.sv
module mem_word_store
  import byte_mem_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 64,
  localparam int unsigned IDX_W      = $clog2(DEPTH_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wword_i,
  output logic [DATA_W-1:0] rword_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH_WORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH_WORDS; i++) lane_mem[i] <= '0;
      end else if (we_i && be_i[l]) begin
        lane_mem[idx_i] <= wword_i[8*l +: 8];
      end
    end

    assign rword_o[8*l +: 8] = lane_mem[idx_i];
  end
endmodule

// File: rtl/byte_mem_ctrl.sv
module byte_mem_ctrl
  import byte_mem_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

  logic [OFS_W-1:0]  ofs;
  logic [IDX_W-1:0]  idx;
  logic              rd_ok, wr_ok;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wword, rword;

  assign ofs = addr_i[OFS_W-1:0];
  assign idx = addr_i[IDX_W+OFS_W-1:OFS_W];  // upper bits alias

  mem_align_chk u_align (
    .en_i      (en_i),
    .op_i      (op_i),
    .ofs_i     (ofs),
    .misalign_o(err_o),
    .rd_ok_o   (rd_ok),
    .wr_ok_o   (wr_ok)
  );

  mem_lane_steer u_steer (
    .op_i   (op_i),
    .ofs_i  (ofs),
    .wdata_i(wdata_i),
    .be_o   (be),
    .wword_o(wword)
  );

  mem_word_store #(.DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok),
    .be_i   (be),
    .idx_i  (idx),
    .wword_i(wword),
    .rword_o(rword)
  );

  assign rdata_o = rd_ok ? rword : '0;
endmodule

// File: rtl/byte_mem_ctrl_chk.sv
module byte_mem_ctrl_chk
  import byte_mem_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!err_o && rdata_o == '0));

  assert_word_misalign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i[1] == op_i[0] && addr_i[1:0] != 2'b00) |-> (err_o && rdata_o == '0));

  assert_half_misalign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_WR_HALF && addr_i[0]) |-> err_o);

  assert_byte_never_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_WR_BYTE) |-> !err_o);

  assert_write_no_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_RD_WORD) |-> (rdata_o == '0));

  assert_word_roundtrip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_RD_WORD && addr_i == $past(addr_i) && $past(rst_ni) &&
     $past(en_i && op_i == OP_WR_WORD && addr_i[1:0] == 2'b00))
    |-> (rdata_o == $past(wdata_i)));
endmodule

bind byte_mem_ctrl byte_mem_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .op_i   (op_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .err_o  (err_o)
);

// File: tb/tb_byte_mem_ctrl.sv
module tb_byte_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WDOG       = 5000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;

  byte_mem_ctrl #(.DEPTH_WORDS(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [7:0]  mdl [DEPTH][4];
  logic [31:0] q_rd[$];
  logic        q_er[$];
  string       q_tg[$];
  bit          done = 1'b0;

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) % DEPTH);
  endfunction

  task automatic access(bit en, logic [1:0] op, logic [31:0] a, logic [31:0] d, string tag);
    logic bad;
    logic [31:0] exp_rd;
    int w;
    @(posedge clk_i);
    #1;
    en_i = en; op_i = op; addr_i = a; wdata_i = d;
    w = widx(a);
    case (op)
      2'b00:   bad = (a[1:0] != 0);
      2'b01:   bad = 1'b0;
      2'b10:   bad = a[0];
      default: bad = (a[1:0] != 0);
    endcase
    bad = bad & en;
    exp_rd = '0;
    if (en && !bad && op == 2'b00)
      exp_rd = {mdl[w][3], mdl[w][2], mdl[w][1], mdl[w][0]};
    q_rd.push_back(exp_rd); q_er.push_back(bad); q_tg.push_back(tag);
    if (en && !bad) begin
      case (op)
        2'b01: mdl[w][a[1:0]] = d[7:0];
        2'b10: begin mdl[w][{a[1],1'b0}] = d[7:0]; mdl[w][{a[1],1'b1}] = d[15:8]; end
        2'b11: for (int k = 0; k < 4; k++) mdl[w][k] = d[8*k +: 8];
        default: ;
      endcase
    end
  endtask

  always @(negedge clk_i) begin
    if (q_rd.size() > 0) begin
      logic [31:0] er; logic ee; string t;
      er = q_rd.pop_front(); ee = q_er.pop_front(); t = q_tg.pop_front();
      checks++;
      if (rdata_o !== er || err_o !== ee) begin
        errors++;
        $display("FAIL %s rdata=%h err=%b expected rdata=%h err=%b", t, rdata_o, err_o, er, ee);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) for (int k = 0; k < 4; k++) mdl[i][k] = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1: cleared after reset
    access(1, 2'b00, 32'h0, 0, "R1");
    access(1, 2'b00, 32'h4, 0, "R1");
    access(1, 2'b00, 32'hFC, 0, "R1");
    // R6 / R3 / R9
    access(1, 2'b11, 32'h8, 32'h1122_3344, "R9");
    access(1, 2'b00, 32'h8, 0, "R3");
    access(1, 2'b11, 32'h10, 32'hDEAD_BEEF, "R6");
    access(1, 2'b00, 32'h10, 0, "R6");
    access(1, 2'b00, 32'h8, 0, "R6");
    // R4: byte lanes, little-endian
    access(1, 2'b01, 32'h9, 32'hFFFF_FFAA, "R4");
    access(1, 2'b00, 32'h8, 0, "R4");
    access(1, 2'b01, 32'hB, 32'h0000_005A, "R4");
    access(1, 2'b01, 32'h8, 32'h0000_0077, "R4");
    access(1, 2'b00, 32'h8, 0, "R4");
    // R5: halfwords
    access(1, 2'b10, 32'hA, 32'hFFFF_BEEF, "R5");
    access(1, 2'b00, 32'h8, 0, "R5");
    access(1, 2'b10, 32'h8, 32'h0000_1234, "R5");
    access(1, 2'b00, 32'h8, 0, "R5");
    // R7: misaligned
    access(1, 2'b10, 32'h11, 32'h0000_5555, "R7");
    access(1, 2'b11, 32'h12, 32'h6666_6666, "R7");
    access(1, 2'b11, 32'h13, 32'h7777_7777, "R7");
    access(1, 2'b00, 32'h10, 0, "R7");
    access(1, 2'b00, 32'h9, 0, "R7");
    access(1, 2'b00, 32'hE, 0, "R7");
    access(1, 2'b01, 32'h13, 32'h0000_0099, "R7");
    access(1, 2'b00, 32'h10, 0, "R7");
    // R2: disabled
    access(0, 2'b11, 32'h8, 32'hFFFF_FFFF, "R2");
    access(0, 2'b00, 32'h9, 0, "R2");
    access(0, 2'b01, 32'h10, 32'h0000_0000, "R2");
    access(1, 2'b00, 32'h8, 0, "R2");
    access(1, 2'b00, 32'h10, 0, "R2");
    // R8: aliasing of upper address bits
    access(1, 2'b11, 32'h8 + DEPTH*4, 32'hCAFE_F00D, "R8");
    access(1, 2'b00, 32'h8, 0, "R8");
    access(1, 2'b01, 32'h8000_0010, 32'h0000_0042, "R8");
    access(1, 2'b00, 32'h10, 0, "R8");
    access(1, 2'b00, 32'hFFFF_FF08, 0, "R8");
    @(posedge clk_i); #1 en_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule